// File: doc/BRIEF.md
# ADC Serial Readout Port

This block is the digital serial front end of a multichannel 14-bit successive-approximation converter. A host reads conversion results over a serial link made of chip select, serial clock, serial data in and serial data out. A frame-sync pin in each direction supports a second framing style that suits signal processors. The converter core is represented by two signals: a one-cycle completion strobe and a parallel 14-bit result word. The block asks the core to start with a one-cycle pulse at the start of every frame.

The block runs on a fast system clock. It samples the serial clock, chip select and frame-sync inputs and finds their edges. In the chip-select mode, pulling chip select low wakes the port and starts a frame, and pulling it high returns the port to shutdown. In the frame-sync mode, a frame-sync pulse seen at a serial clock rising edge starts a frame, and the frame ends by itself once the result has been sent. In both modes, data out stays low during a lead-in of 8 or 16 serial clock falling edges, set by the transfer length. After the lead-in the result is sent most significant bit first.

Top module: `adc_serial_port`

## Requirements
- R1: In chip-select mode, a rising chip select ends the frame: `awake` and `sdo_en` go low one clock after the rise is seen, and they stay low while chip select is high.
- R2: With `cfg_dsp`=0, a falling chip select starts a frame: `awake` and `sdo_en` go high, `sdo` is 0, and `conv_go` pulses once.
- R3: `sdo` is 0 until the MSB is launched. If the result was captured before the lead-th serial clock falling edge of the frame, the MSB appears on that edge. The lead is 8 when the length setting is 0 and 16 when it is 1.
- R4: If the result is captured after that edge, the MSB appears on the first falling edge after the capture.
- R5: The 14 result bits are sent as straight binary, MSB first, one bit per falling edge. Every later bit slot of the frame is driven 0.
- R6: With `cfg_dsp`=1, `fs_in` high at a serial clock rising edge starts a frame and pulses `conv_go` once. Chip select has no effect on such a frame.
- R7: `fs_out` is high for exactly one serial clock period. It starts on the falling edge that launches the MSB, and it is only ever high in a frame-sync mode frame.
- R8: A frame-sync mode frame ends on the falling edge after the LSB has been sent, and `sdo_en` then goes to 0.
- R9: `cfg_dsp` and `cfg_len16` are taken only when a frame starts. Changing them during a frame has no effect.
- R10: During a frame, `sdi` is sampled on every serial clock rising edge into `rx_data`, with the newest bit in bit 0.
- R11: `conv_done` is ignored while the port is idle and after a result has been captured in the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| fs_in | input | 1 | Frame-sync input for frame-sync mode |
| cfg_dsp | input | 1 | 1 selects frame-sync mode |
| cfg_len16 | input | 1 | 1 selects the 16-edge lead-in, 0 the 8-edge lead-in |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 14 | Converter result word |
| conv_go | output | 1 | One-cycle pulse at the start of a frame |
| awake | output | 1 | High while a frame is active |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for `sdo`; 0 means tri-stated |
| fs_out | output | 1 | Frame-sync output, marks the MSB |
| rx_data | output | 16 | Last 16 `sdi` bits sampled |

## Verification
The hardest cases to reach are a late result, which moves the MSB past the lead-in edge, and a second completion strobe that arrives after a capture and carries different data. To reach them, the bench places the completion strobe after a random number of falling edges, up to well past 16. It then sends a spurious strobe with other data two edges later. Random frames also cut chip-select transfers short at arbitrary slots, flip the configuration inputs in the middle of a frame, and toggle chip select during frame-sync frames.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W      = 14,
  parameter int SHORT_LEAD = 8,
  parameter int LONG_LEAD  = 16,
  parameter int RX_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             fs_in,
  input  logic             cfg_dsp,
  input  logic             cfg_len16,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             conv_go,
  output logic             awake,
  output logic             sdo,
  output logic             sdo_en,
  output logic             fs_out,
  output logic [RX_W-1:0]  rx_data
);
  localparam int CW = $clog2(LONG_LEAD + 1);
  localparam int BW = $clog2(RES_W);

  logic sclk_q, cs_q;
  logic active, mode_dsp, len16, have_res, launched, go_q, sdo_q, fs_q;
  logic [CW-1:0]    fcnt;
  logic [BW-1:0]    bits_left;
  logic [RES_W-1:0] res, shreg;
  logic [RX_W-1:0]  rx_q;

  wire sclk_rise = sclk & ~sclk_q;
  wire sclk_fall = ~sclk & sclk_q;
  wire cs_fall   = ~cs_n & cs_q;
  wire cs_rise   = cs_n & ~cs_q;

  wire [CW-1:0] lead    = len16 ? CW'(LONG_LEAD) : CW'(SHORT_LEAD);
  wire [CW-1:0] fcnt_nx = (fcnt == CW'(LONG_LEAD)) ? fcnt : fcnt + 1'b1;
  wire start  = !active && (cfg_dsp ? (sclk_rise && fs_in) : cs_fall);
  wire launch = have_res && !launched && (fcnt_nx >= lead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; cs_q <= 1'b1;
      active <= 1'b0; mode_dsp <= 1'b0; len16 <= 1'b0;
      have_res <= 1'b0; launched <= 1'b0; go_q <= 1'b0;
      sdo_q <= 1'b0; fs_q <= 1'b0;
      fcnt <= '0; bits_left <= '0; res <= '0; shreg <= '0; rx_q <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      go_q   <= 1'b0;
      if (start) begin
        active <= 1'b1; mode_dsp <= cfg_dsp; len16 <= cfg_len16;
        fcnt <= '0; have_res <= 1'b0; launched <= 1'b0; bits_left <= '0;
        sdo_q <= 1'b0; fs_q <= 1'b0; go_q <= 1'b1;
      end else if (active) begin
        if (!mode_dsp && cs_rise) begin
          active <= 1'b0; sdo_q <= 1'b0; fs_q <= 1'b0;
        end else begin
          if (conv_done && !have_res) begin
            res <= conv_data;
            have_res <= 1'b1;
          end
          if (sclk_rise) rx_q <= {rx_q[RX_W-2:0], sdi};
          if (sclk_fall) begin
            fcnt <= fcnt_nx;
            fs_q <= 1'b0;
            if (launch) begin
              sdo_q <= res[RES_W-1];
              shreg <= res << 1;
              bits_left <= BW'(RES_W - 1);
              launched <= 1'b1;
              fs_q <= mode_dsp;
            end else if (launched && bits_left != '0) begin
              sdo_q <= shreg[RES_W-1];
              shreg <= shreg << 1;
              bits_left <= bits_left - 1'b1;
            end else begin
              sdo_q <= 1'b0;
              if (launched && mode_dsp) active <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign conv_go = go_q;
  assign awake   = active;
  assign sdo_en  = active;
  assign sdo     = sdo_q;
  assign fs_out  = fs_q;
  assign rx_data = rx_q;

  AST_CS_RISE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mode_dsp && cs_rise) |=> !active); // R1
  AST_LOW_BEFORE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !launched) |-> !sdo_q); // R3
  AST_FS_DSP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (active && mode_dsp)); // R7
  AST_FS_AT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_q) |-> (launched && bits_left == BW'(RES_W - 1))); // R7
  AST_FS_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && sclk_fall) |=> !fs_q); // R7
endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  localparam int H = 4;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sclk = 0, sdi = 0, fs_in = 0, cfg_dsp = 0, cfg_len16 = 0, conv_done = 0;
  logic [13:0] conv_data = '0;
  logic conv_go, awake, sdo, sdo_en, fs_out;
  logic [15:0] rx_data;
  int checks = 0, errors = 0, go_cnt = 0;
  logic [15:0] exp_rx = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (conv_go) go_cnt++;

  adc_serial_port i_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .fs_in(fs_in),
    .cfg_dsp(cfg_dsp), .cfg_len16(cfg_len16), .conv_done(conv_done), .conv_data(conv_data),
    .conv_go(conv_go), .awake(awake), .sdo(sdo), .sdo_en(sdo_en), .fs_out(fs_out),
    .rx_data(rx_data));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int launch_at(bit l16, int j);
    int n = l16 ? 16 : 8;
    return (j + 1 > n) ? j + 1 : n;
  endfunction

  function automatic bit exp_bit(int f, int l, logic [13:0] r);
    return (f >= l && f < l + 14) ? r[13 - (f - l)] : 1'b0;
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(bit dsp, bit l16, int j, logic [13:0] r, int nslots);
    int l = launch_at(l16, j);
    int go0 = go_cnt;
    string tag;
    cfg_dsp = dsp; cfg_len16 = l16;
    if (dsp) begin
      @(negedge clk) fs_in = 1;
      @(negedge clk) sclk = 1;
      wait_n(H);
      fs_in = 0;
    end else begin
      @(negedge clk) cs_n = 0;
      wait_n(3);
    end
    cfg_len16 = ~l16; // R9: change after start must not matter
    cfg_dsp = ~dsp;
    tag = dsp ? "R6" : "R2";
    chk(awake && sdo_en && !sdo, tag, "frame open", {awake, sdo_en, sdo}, 3'b110);
    chk(go_cnt == go0 + 1, tag, "conv_go pulses", go_cnt - go0, 1);
    for (int f = 1; f <= nslots; f++) begin
      if (!(dsp && f == 1)) begin
        @(negedge clk);
        sdi = 1'($urandom);
        sclk = 1;
        exp_rx = {exp_rx[14:0], sdi};
      end
      @(negedge clk);
      if (f - 1 == j) begin conv_data = r; conv_done = 1; end
      else if (f - 1 == j + 2) begin conv_data = ~r; conv_done = 1; end // R11
      if (dsp && f == 3) cs_n = 0; // R6: chip select ignored
      @(negedge clk);
      conv_done = 0; conv_data = 14'($urandom);
      if (dsp && f == 3) cs_n = 1;
      wait_n(H - 2);
      sclk = 0;
      wait_n(H);
      if (f < l) tag = (j + 1 > (l16 ? 16 : 8)) ? "R4" : "R3";
      else tag = "R5";
      chk(sdo == exp_bit(f, l, r), tag, $sformatf("sdo slot %0d", f), sdo, exp_bit(f, l, r));
      chk(fs_out == (dsp && f == l), "R7", $sformatf("fs_out slot %0d", f), fs_out, dsp && f == l);
      if (dsp) chk(sdo_en == (f < l + 14), "R8", $sformatf("sdo_en slot %0d", f), sdo_en, f < l + 14);
      else chk(sdo_en, "R9", $sformatf("sdo_en slot %0d", f), sdo_en, 1);
    end
    if (!dsp) begin
      @(negedge clk) cs_n = 1;
      wait_n(3);
      chk(!sdo_en && !awake, "R1", "shutdown on cs high", {sdo_en, awake}, 0);
    end else begin
      wait_n(2);
      chk(!sdo_en && !awake, "R8", "frame-sync frame closed", {sdo_en, awake}, 0);
    end
    chk(rx_data == exp_rx, "R10", "rx_data", rx_data, exp_rx);
    wait_n(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    wait_n(4);
    chk(!sdo_en && !awake && !fs_out && !conv_go, "R1", "reset state",
        {sdo_en, awake, fs_out, conv_go}, 0);
    rst_n = 1;
    wait_n(4);
    @(negedge clk) cs_n = 0;
    wait_n(2);
    @(negedge clk) cs_n = 1;
    wait_n(4);
    chk(!awake && !sdo_en, "R1", "cs high after short low", {awake, sdo_en}, 0);
    run_frame(0, 0, 0, 14'h2A5C, 24);
    run_frame(0, 1, 0, 14'h3FFF, 32);
    run_frame(0, 0, 20, 14'h0001, 36);
    run_frame(1, 0, 0, 14'h1234, 22);
    run_frame(1, 1, 18, 14'h2001, 33);
    @(negedge clk) begin conv_data = 14'h3C3C; conv_done = 1; end // R11: idle strobe
    @(negedge clk) conv_done = 0;
    run_frame(0, 0, 40, 14'h0, 28);
    for (int k = 0; k < 40; k++) begin
      bit d = 1'($urandom);
      bit l16 = 1'($urandom);
      int j = int'($urandom % 24);
      logic [13:0] r = 14'($urandom);
      int n = d ? launch_at(l16, j) + 14 : 4 + int'($urandom % 36);
      run_frame(d, l16, j, r, n);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule